// File: doc/BRIEF.md
# Interrupt Control Register Unit

This block is the interrupt front end of a small 8-bit processor core. It holds one 8-bit control and status register that software can read and write. The register has five enable bits and three event flags. Three event sources feed the flags:

- a one-cycle pulse from a timer when it rolls over;
- an external interrupt pin;
- a port-change detector that watches a parallel input port through a per-pin mask.

A combined request from the peripheral group enters through a separate input. The block drives a single interrupt request line to the core.

Each flag records its event whether or not any enable bit is set. A flag stays set until software writes 0 to it. The request line is built through two levels of gating. The global enable governs everything. A peripheral enable governs the peripheral group.

The external pin and the port bits are asynchronous, so each passes through a two-stage synchroniser. The timer pulse is synchronous to the block clock.

Top module: `irq_ctrl_unit`

## Requirements
- R1: While reset is active, and after it is released, the five enable bits and the timer and pin flags read 0 and `irq` is low. The port-change flag has no defined reset value.
- R2: `ctl_rdata` shows the register with bit 7 as the global enable and bit 6 as the peripheral enable. Bits 5, 4 and 3 are the timer, pin and port-change enables. Bits 2, 1 and 0 are the timer, pin and port-change flags. A write with `ctl_we` high stores all eight bits of `ctl_wdata` at the next clock edge.
- R3: A high `tmr_wrap` at a clock edge sets the timer flag (bit 2) at that edge, whatever the enable bits hold.
- R4: A rising edge on `ext_pin` sets the pin flag (bit 1) at the third clock edge after the pin goes high. A falling edge leaves the flag unchanged.
- R5: A change of a `port_in` bit in either direction sets the port-change flag (bit 0) at the third clock edge after the change, but only when the matching `chg_mask` bit is 1. A change on a pin whose mask bit is 0 never sets the flag.
- R6: A set flag stays set through any number of idle cycles. It is cleared only by a register write that puts 0 in that bit position.
- R7: When a flag's event and a register write of 0 to that flag fall on the same clock edge, the flag ends up set.
- R8: `irq` equals bit 7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_irq`)). It stays low whenever bit 7 is 0.
- R9: `periph_irq` raises `irq` only when both bit 7 and bit 6 are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Current register contents |
| tmr_wrap | input | 1 | Timer roll-over pulse, one cycle |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_in | input | PORT_W | Asynchronous watched port |
| chg_mask | input | PORT_W | Per-pin change-detect enable |
| periph_irq | input | 1 | Combined peripheral-group request |
| irq | output | 1 | Interrupt request to the core |

## Verification
The register is visible at `ctl_rdata`, so a lost or false flag shows on the read port at the very edge where the event is taken. That is three edges after the pin or port change, or one edge after the timer pulse. A wrong enable bit, or a gating fault, shows on `irq` in the same cycle as the register value that should have masked or passed it. For this reason the bench sweeps every register value against both levels of `periph_irq`. A stale synchroniser copy or a wrong mask term would show up as a flag that sets one edge early or late, or sets for a masked pin. The bench therefore samples the flag on both sides of the expected edge.

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              tmr_wrap,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] chg_mask,
  input  logic              periph_irq,
  output logic              irq
);
  localparam int EN_W = 5;

  logic [EN_W-1:0]        en_q;
  logic                   tmr_f, pin_f, chg_f;
  logic [SYNC_STAGES:0]   pin_s;
  logic [PORT_W-1:0]      port_s [SYNC_STAGES];
  logic [PORT_W-1:0]      port_last;
  logic                   pin_rise, port_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_s <= '0;
    else        pin_s <= {pin_s[SYNC_STAGES-1:0], ext_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) port_s[i] <= '0;
      port_last <= '0;
    end else begin
      port_s[0] <= port_in;
      for (int i = 1; i < SYNC_STAGES; i++) port_s[i] <= port_s[i-1];
      port_last <= port_s[SYNC_STAGES-1];
    end

  assign pin_rise = pin_s[SYNC_STAGES-1] & ~pin_s[SYNC_STAGES];
  assign port_hit = |((port_s[SYNC_STAGES-1] ^ port_last) & chg_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      tmr_f <= 1'b0;
      pin_f <= 1'b0;
    end else begin
      if (ctl_we) en_q <= ctl_wdata[7:3];
      tmr_f <= tmr_wrap | (ctl_we ? ctl_wdata[2] : tmr_f);
      pin_f <= pin_rise | (ctl_we ? ctl_wdata[1] : pin_f);
    end

  always_ff @(posedge clk)
    chg_f <= port_hit | (ctl_we ? ctl_wdata[0] : chg_f);

  assign ctl_rdata = {en_q, tmr_f, pin_f, chg_f};

  assign irq = en_q[4] & ((en_q[2] & tmr_f) | (en_q[1] & pin_f) |
                          (en_q[0] & chg_f) | (en_q[3] & periph_irq));
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       tmr_wrap,
  input logic       periph_irq,
  input logic       irq
);
  p_gie_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[7] |-> !irq);
  p_periph_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && ctl_rdata[6] && periph_irq) |-> irq);
  p_tmr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> ctl_rdata[2]);
  p_tmr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2] && !ctl_we) |=> ctl_rdata[2]);
  p_pin_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[1] && !ctl_we) |=> ctl_rdata[1]);
  p_en_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata[7:3] == $past(ctl_wdata[7:3]));
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata[7:3]));
  always_comb if (!rst_n) p_reset_r1: assert (ctl_rdata[7:1] == 7'd0 && !irq);
endmodule

bind irq_ctrl_unit irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .tmr_wrap(tmr_wrap), .periph_irq(periph_irq),
  .irq(irq)
);

// File: tb/test_irq_ctrl_unit.sv
module test_irq_ctrl_unit;
  logic       clk = 0, rst_n = 0, ctl_we = 0, tmr_wrap = 0, ext_pin = 0, periph_irq = 0;
  logic [7:0] ctl_wdata = 0, port_in = 0, chg_mask = 0;
  logic [7:0] ctl_rdata;
  logic       irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  irq_ctrl_unit i_irq_ctrl_unit (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .tmr_wrap(tmr_wrap),
    .ext_pin(ext_pin), .port_in(port_in), .chg_mask(chg_mask),
    .periph_irq(periph_irq), .irq(irq));

  always #5ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state, bit 0 undefined
    chk(ctl_rdata[7:1] == 0 && !irq, "R1", {ctl_rdata[7:1], irq}, 0);
    rst_n = 1;
    cyc(2);
    chk(ctl_rdata[7:1] == 0 && !irq, "R1 after release", {ctl_rdata[7:1], irq}, 0);

    // R2 R8 R9 exhaustive register x periph sweep
    for (int v = 0; v < 256; v++)
      for (int p = 0; p < 2; p++) begin
        logic [7:0] r;
        logic e;
        r = v[7:0];
        periph_irq = p[0];
        wr(r);
        e = r[7] & ((r[5] & r[2]) | (r[4] & r[1]) | (r[3] & r[0]) | (r[6] & p[0]));
        chk(ctl_rdata == r, "R2", ctl_rdata, r);
        chk(irq == e, r[7] ? (r[6] && p[0] ? "R9" : "R8") : "R8 gie off", irq, e);
      end
    periph_irq = 0;

    // R3 timer flag with all enables off
    wr(8'h00);
    @(negedge clk); tmr_wrap = 1; @(negedge clk); tmr_wrap = 0; #1;
    chk(ctl_rdata == 8'h04, "R3", ctl_rdata, 8'h04);
    chk(!irq, "R8 flag with enables off", irq, 0);
    cyc(10);
    chk(ctl_rdata[2] == 1, "R6 sticky", ctl_rdata[2], 1);
    wr(8'hA4);
    chk(irq == 1, "R8 late enable", irq, 1);
    wr(8'h00);
    chk(ctl_rdata[2] == 0, "R6 clear", ctl_rdata[2], 0);

    // R7 set wins over clear
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h00; tmr_wrap = 1;
    @(negedge clk); ctl_we = 0; tmr_wrap = 0; #1;
    chk(ctl_rdata == 8'h04, "R7", ctl_rdata, 8'h04);

    // R4 pin rising edge, third edge
    wr(8'h00);
    @(negedge clk); ext_pin = 1;
    cyc(2);
    chk(ctl_rdata[1] == 0, "R4 early", ctl_rdata[1], 0);
    cyc(1);
    chk(ctl_rdata[1] == 1, "R4", ctl_rdata[1], 1);
    cyc(6);
    chk(ctl_rdata[1] == 1, "R6 pin sticky", ctl_rdata[1], 1);
    wr(8'h00);
    @(negedge clk); ext_pin = 0;
    cyc(6);
    chk(ctl_rdata[1] == 0, "R4 falling", ctl_rdata[1], 0);

    // R5 per-pin mask sweep, both directions
    for (int i = 0; i < 8; i++) begin
      chg_mask = ~(8'h01 << i);
      wr(8'h00);
      @(negedge clk); port_in[i] = ~port_in[i];
      cyc(6);
      chk(ctl_rdata[0] == 0, "R5 masked pin", ctl_rdata[0], 0);
      chg_mask = 8'h01 << i;
      wr(8'h00);
      @(negedge clk); port_in[i] = ~port_in[i];
      cyc(2);
      chk(ctl_rdata[0] == 0, "R5 early", ctl_rdata[0], 0);
      cyc(1);
      chk(ctl_rdata[0] == 1, "R5 enabled pin", ctl_rdata[0], 1);
    end
    wr(8'h89);
    chk(irq == 1, "R8 port path", irq, 1);
    finish_run();
  end
endmodule